// File: doc/BRIEF.md
# Tone-Event Interrupt Queue

This block gathers tone-disable activity from a set of echo-canceller channels and hands it to a host processor one event at a time. Each channel supplies a status level. Any change of that level, whether it rises (tone found) or falls (tone gone), counts as one event. The number of the channel that changed is placed in a first-in first-out queue.

The host is told about waiting events through an active-low interrupt line. It reads the queue through one read strobe. The head entry is always visible on the read-data port, together with a valid flag. A strobe pops that entry. After every read the interrupt line goes high for at least one clock. It then drops again if entries remain, so the host sees one low pulse per queued event.

When several channels change in the same clock, per-channel pending flags keep every event. The flags drain into the queue one per clock, lowest channel first. An event that finds the queue full is discarded, and a sticky overflow flag records the loss.

Top module: `tone_event_irq`

## Requirements
- R1: After reset, `irqN` is 1, `rdValid` is 0, `rdChan` is 0 and `overflow` is 0.
- R2: A 0-to-1 change on `toneStatus[i]` queues one entry holding the value i. The entry shows on `rdChan`, with `rdValid`=1, two clocks after the change is sampled when the queue was empty.
- R3: A 1-to-0 change on `toneStatus[i]` also queues one entry holding i.
- R4: Channels that change in the same clock are queued one per clock in ascending channel number. No event is lost.
- R5: Entries are read oldest first. A clock with `hostRd`=1 removes the entry shown on `rdChan` at that clock.
- R6: When the queue is empty, `rdChan` is 0 and `rdValid` is 0. A read strobe on an empty queue changes nothing, and events that arrive later are still queued normally.
- R7: `irqN` is 0 only while at least one entry is queued. It becomes 0 one clock after the queue turns non-empty. It is 1 in the clock after every clock in which `hostRd`=1.
- R8: After the high clock that follows a read, `irqN` returns to 0 if entries remain, giving one low pulse per queued entry.
- R9: The queue holds `DEPTH` (default 8, at least twice the channel count) entries. An event arriving while the queue is full and not being read is dropped. It sets `overflow` to 1, and `overflow` stays 1 until reset.
- R10: Reset empties the queue and clears the stored entries to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| toneStatus | input | NUM_CH | Per-channel tone-disable status level |
| hostRd | input | 1 | Host read strobe; pops the head entry |
| irqN | output | 1 | Active-low interrupt request |
| rdChan | output | $clog2(NUM_CH) | Channel number at the queue head; 0 when empty |
| rdValid | output | 1 | 1 when `rdChan` holds a queued entry |
| overflow | output | 1 | Sticky flag set when an event was dropped |

## Verification
Several properties are checked on every clock by assertions:
- the interrupt is high after every read;
- the interrupt is low only while entries exist;
- a falling interrupt edge is never directly preceded by a read;
- the arbiter grants at most one channel;
- the overflow flag never clears;
- an empty read leaves the queue empty;
- the fill count stays within the depth.

Some behaviour can only be shown by the directed scenarios, because it depends on the values stored and their order. These include:
- that each edge direction yields the right channel number;
- that simultaneous changes arrive in ascending order;
- that the queue returns entries oldest first;
- that exactly the event past the depth is the one dropped.

// File: rtl/tone_event_irq_pkg.sv
package tone_event_irq_pkg;
  // Strobes from control to the queue datapath
  typedef struct packed {
    logic push;  // write pushChan into the queue this clock
    logic pop;   // remove the head entry this clock
  } fifoStrb_t;
endpackage

// File: rtl/tone_event_irq_ctrl.sv
module tone_event_irq_ctrl
  import tone_event_irq_pkg::*;
#(
  parameter int NUM_CH = 4,
  localparam int CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [NUM_CH-1:0] toneStatus,
  input  logic              hostRd,
  input  logic              notEmpty,
  output fifoStrb_t         strb,
  output logic [CH_W-1:0]   pushChan,
  output logic              irqN
);
  logic [NUM_CH-1:0] statusQ;
  logic [NUM_CH-1:0] pendQ;
  logic [NUM_CH-1:0] edgeHit;
  logic [NUM_CH-1:0] grant;
  logic              irqNQ;

  // Both directions of a status change count as an event
  assign edgeHit = toneStatus ^ statusQ;

  // Lowest pending channel wins
  always_comb begin
    grant    = '0;
    pushChan = '0;
    for (int i = NUM_CH - 1; i >= 0; i--) begin
      if (pendQ[i]) begin
        grant    = '0;
        grant[i] = 1'b1;
        pushChan = CH_W'(i);
      end
    end
  end

  assign strb.push = |pendQ;
  assign strb.pop  = hostRd;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      statusQ <= '0;
      pendQ   <= '0;
    end else begin
      statusQ <= toneStatus;
      pendQ   <= (pendQ & ~grant) | edgeHit;
    end
  end

  // Interrupt: forced high after a read, otherwise follows queue occupancy
  always_ff @(posedge clk) begin
    if (!rstN)       irqNQ <= 1'b1;
    else if (hostRd) irqNQ <= 1'b1;
    else             irqNQ <= !notEmpty;
  end
  assign irqN = irqNQ;

  a_r4_grant_onehot: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(grant));
  a_r2_edge_pends: assert property (@(posedge clk) disable iff (!rstN)
    (|edgeHit) |=> (|pendQ));
  a_r7_high_after_read: assert property (@(posedge clk) disable iff (!rstN)
    hostRd |=> irqN);
  a_r8_gap_before_pulse: assert property (@(posedge clk) disable iff (!rstN)
    $fell(irqN) |-> !$past(hostRd));
endmodule

// File: rtl/tone_event_irq_dp.sv
module tone_event_irq_dp
  import tone_event_irq_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int DEPTH  = 8,
  localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic            clk,
  input  logic            rstN,
  input  fifoStrb_t       strb,
  input  logic [CH_W-1:0] pushChan,
  output logic            notEmpty,
  output logic [CH_W-1:0] rdChan,
  output logic            rdValid,
  output logic            overflow
);
  logic [CH_W-1:0]  memQ [DEPTH];
  logic [PTR_W-1:0] wrPtr, rdPtr;
  logic [CNT_W-1:0] cnt;
  logic             full, doPush, doPop, overflowQ;

  assign full     = (cnt == CNT_W'(DEPTH));
  assign notEmpty = (cnt != '0);
  assign doPop    = strb.pop && notEmpty;
  assign doPush   = strb.push && (!full || doPop);

  function automatic logic [PTR_W-1:0] nextPtr(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  for (genvar g = 0; g < DEPTH; g++) begin : gSlot
    always_ff @(posedge clk) begin
      if (!rstN)                              memQ[g] <= '0;
      else if (doPush && wrPtr == PTR_W'(g))  memQ[g] <= pushChan;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr     <= '0;
      rdPtr     <= '0;
      cnt       <= '0;
      overflowQ <= 1'b0;
    end else begin
      if (doPush) wrPtr <= nextPtr(wrPtr);
      if (doPop)  rdPtr <= nextPtr(rdPtr);
      case ({doPush, doPop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
      if (strb.push && !doPush) overflowQ <= 1'b1;
    end
  end

  assign rdValid  = notEmpty;
  assign rdChan   = notEmpty ? memQ[rdPtr] : '0;
  assign overflow = overflowQ;

  a_r9_overflow_sticky: assert property (@(posedge clk) disable iff (!rstN)
    overflowQ |=> overflowQ);
  a_r6_empty_read_keeps: assert property (@(posedge clk) disable iff (!rstN)
    (strb.pop && !strb.push && cnt == '0) |=> (cnt == '0));
  a_r9_count_bound: assert property (@(posedge clk) disable iff (!rstN)
    cnt <= CNT_W'(DEPTH));
  a_r6_zero_when_empty: assert property (@(posedge clk) disable iff (!rstN)
    !rdValid |-> (rdChan == '0));
endmodule

// File: rtl/tone_event_irq.sv
module tone_event_irq
  import tone_event_irq_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int DEPTH  = 8,
  localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [NUM_CH-1:0] toneStatus,
  input  logic              hostRd,
  output logic              irqN,
  output logic [CH_W-1:0]   rdChan,
  output logic              rdValid,
  output logic              overflow
);
  fifoStrb_t       strb;
  logic [CH_W-1:0] pushChan;
  logic            notEmpty;

  tone_event_irq_ctrl #(.NUM_CH(NUM_CH)) uCtrl (
    .clk(clk), .rstN(rstN), .toneStatus(toneStatus), .hostRd(hostRd),
    .notEmpty(notEmpty), .strb(strb), .pushChan(pushChan), .irqN(irqN)
  );

  tone_event_irq_dp #(.NUM_CH(NUM_CH), .DEPTH(DEPTH)) uDp (
    .clk(clk), .rstN(rstN), .strb(strb), .pushChan(pushChan),
    .notEmpty(notEmpty), .rdChan(rdChan), .rdValid(rdValid),
    .overflow(overflow)
  );

  a_r7_low_only_pending: assert property (@(posedge clk) disable iff (!rstN)
    !irqN |-> rdValid);
endmodule

// File: tb/sim_tone_event_irq.sv
module sim_tone_event_irq;
  localparam int NUM_CH = 4;
  localparam int DEPTH  = 8;
  localparam int CH_W   = $clog2(NUM_CH);

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic [NUM_CH-1:0] toneStatus = '0;
  logic              hostRd = 1'b0;
  logic              irqN;
  logic [CH_W-1:0]   rdChan;
  logic              rdValid;
  logic              overflow;

  int nChk = 0;
  int nBad = 0;

  always #4 clk = ~clk;  // 125 MHz

  tone_event_irq #(.NUM_CH(NUM_CH), .DEPTH(DEPTH)) u0 (
    .clk(clk), .rstN(rstN), .toneStatus(toneStatus), .hostRd(hostRd),
    .irqN(irqN), .rdChan(rdChan), .rdValid(rdValid), .overflow(overflow)
  );

  task automatic chk(input int act, input int exp, input string what);
    nChk++;
    if (act != exp) begin
      nBad++;
      $display("FAIL %s: actual %0d expected %0d", what, act, exp);
    end
  endtask

  task automatic waitN(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // Checks the head, pops it and checks the interrupt around the read
  task automatic readEntry(input int expChan, input bit moreAfter, input string tag);
    chk(rdValid, 1, {tag, " valid at head"});
    chk(rdChan, expChan, {tag, " head channel"});
    hostRd = 1'b1;
    @(negedge clk);
    hostRd = 1'b0;
    chk(irqN, 1, "R7 irqN high after read");
    @(negedge clk);
    chk(irqN, moreAfter ? 0 : 1, "R8 irqN re-pulse for remaining entries");
    chk(rdValid, moreAfter ? 1 : 0, {tag, " valid after pop"});
  endtask

  task automatic doReset();
    rstN = 1'b0; toneStatus = '0; hostRd = 1'b0;
    waitN(3);
    rstN = 1'b1;
    @(negedge clk);
  endtask

  task automatic tReset();
    doReset();
    chk(irqN, 1, "R1 irqN after reset");
    chk(rdValid, 0, "R1 rdValid after reset");
    chk(rdChan, 0, "R1 rdChan after reset");
    chk(overflow, 0, "R1 overflow after reset");
  endtask

  task automatic tRise();
    toneStatus[2] = 1'b1;
    @(negedge clk);
    chk(rdValid, 0, "R2 not yet queued after one clock");
    @(negedge clk);
    chk(rdValid, 1, "R2 queued after two clocks");
    chk(rdChan, 2, "R2 rising event channel");
    chk(irqN, 1, "R7 irqN not yet low");
    @(negedge clk);
    chk(irqN, 0, "R7 irqN low while pending");
    readEntry(2, 0, "R2");
  endtask

  task automatic tFall();
    toneStatus[2] = 1'b0;
    waitN(3);
    chk(irqN, 0, "R3 irqN low on release event");
    readEntry(2, 0, "R3");
  endtask

  task automatic tSimul();
    toneStatus = 4'b1011;  // channels 3, 1, 0 change together
    waitN(6);
    readEntry(0, 1, "R4 first");
    readEntry(1, 1, "R4 second");
    readEntry(3, 0, "R5 third");
  endtask

  task automatic tEmptyRead();
    chk(rdValid, 0, "R6 empty valid");
    chk(rdChan, 0, "R6 empty channel zero");
    hostRd = 1'b1;
    @(negedge clk);
    hostRd = 1'b0;
    @(negedge clk);
    chk(rdValid, 0, "R6 empty read leaves queue empty");
    chk(irqN, 1, "R6 irqN stays high");
    toneStatus[1] = 1'b0;
    waitN(3);
    readEntry(1, 0, "R6 later event");
  endtask

  task automatic tOverflow();
    toneStatus = ~toneStatus;
    waitN(5);
    toneStatus = ~toneStatus;
    waitN(5);
    chk(overflow, 0, "R9 no overflow at exactly full");
    toneStatus[2] = ~toneStatus[2];
    waitN(4);
    chk(overflow, 1, "R9 overflow set on drop");
    for (int k = 0; k < DEPTH; k++)
      readEntry(k % NUM_CH, (k != DEPTH - 1), "R9 drain");
    chk(overflow, 1, "R9 overflow sticky");
  endtask

  task automatic tResetClear();
    toneStatus[0] = ~toneStatus[0];
    waitN(3);
    chk(rdValid, 1, "R10 entry before reset");
    doReset();
    chk(rdValid, 0, "R10 queue empty after reset");
    chk(rdChan, 0, "R10 channel zero after reset");
    chk(overflow, 0, "R10 overflow cleared");
    chk(irqN, 1, "R10 irqN high after reset");
  endtask

  initial begin
    tReset();
    tRise();
    tFall();
    tSimul();
    tEmptyRead();
    tOverflow();
    tResetClear();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    nChk++;
    nBad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end
endmodule